// File: doc/BRIEF.md
# Per-Area External Bus Access Sequencer

This block runs accesses to external memory for a CPU. The 24-bit address space is split into eight equal areas. The area number comes from the top three address bits. Each area has three settings of its own: an 8-bit or 16-bit data path, a bus cycle of two or three states, and a count of zero to three program wait states. When a request arrives, the block finds the target area and pulls that area's active-low chip select. It holds the select through every state of the cycle and then pulses done.

A word request to an 8-bit area becomes two byte cycles, run back to back under one unbroken chip select. The even (upper) byte goes first, and each byte cycle takes the area's full state and wait count. The area settings sit in a small register file behind a write port. A request copies the settings of its area at the moment it is accepted, so a write made during an access only takes effect on the next one. Chip selects 1 to 3 have separate output-enable bits and stay undriven until software turns them on.

Top module: `ext_bus_seq`

## Requirements
- R1: The area index is `req_addr[23:21]`. During an access, exactly `cs_n[area]` is low and every other `cs_n` bit is high.
- R2: After reset, every area is 16-bit with 3-state cycles and 3 waits, so an access holds chip select low for 6 clocks.
- R3: With the area's state bit at 0 (2-state), chip select is low for exactly 2 clocks, whatever the area's wait field holds.
- R4: With the area's state bit at 1 (3-state), chip select is low for 3 + W clocks, where W is the area's 2-bit wait field.
- R5: A word request (`req_word`=1) to an area whose width bit is 1 (8-bit) runs two cycles of N clocks each, with chip select low for 2N clocks in a row. `bus_addr` holds `{req_addr[23:1],0}` in the first cycle and `{req_addr[23:1],1}` in the second.
- R6: A byte request, or any request to a 16-bit area, runs a single cycle, and `bus_addr` equals `req_addr`.
- R7: A request is taken only while `busy` is low. `busy` stays high from the clock after acceptance through the done clock. `done` is high for one clock, the clock right after chip select returns high. Requests made while busy are ignored.
- R8: Chip select stays high for at least one clock between two accesses.
- R9: `cs_oe[0]` and `cs_oe[7:4]` are always 1. `cs_oe[3:1]` reset to 0 and follow the direction register (`cfg_sel`=3, `cfg_wdata[2:0]`).
- R10: A configuration write made during an access does not change that access. The next access uses the new value.
- R11: The configuration write port has these encodings. `cfg_sel`=0 writes the width bits (`cfg_wdata[n]` for area n; 1 means 8-bit). `cfg_sel`=1 writes the state bits (`cfg_wdata[n]`; 1 means 3-state). `cfg_sel`=2 writes the wait fields (`cfg_wdata[2n+1:2n]`). `cfg_sel`=3 writes the direction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Selects which configuration register is written |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Access request |
| req_addr | input | 24 | Access address |
| req_write | input | 1 | 1 for a write access |
| req_word | input | 1 | 1 for a 16-bit transfer, 0 for a byte |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-clock completion pulse |
| cs_n | output | 8 | Active-low chip select for each area |
| cs_oe | output | 8 | Output enable for each chip-select pin |
| bus_addr | output | 24 | Address of the current bus cycle |
| bus_we | output | 1 | Direction of the current access |

## Verification
Directed accesses try the reset configuration, then a 2-state area whose wait field is nonzero, then 3-state areas with each wait count. Together these show whether the wait field is properly gated by the state bit. Word and byte requests to 8-bit and 16-bit areas show whether a request is split in two and in which byte order. Two further stimuli test isolation: a configuration write made in the middle of an access, and requests held high during an access. Each should leave the running access unchanged. Random accesses are then mixed with random configuration writes and compared with a bench model of the per-area settings.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
   localparam int WAIT_W = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_FIN  = 2'd2
   } seq_st_e;

   typedef struct packed {
      logic              narrow;
      logic              slow;
      logic [WAIT_W-1:0] waits;
   } area_cfg_t;
endpackage

// File: rtl/ebs_cfg_regs.sv
module ebs_cfg_regs
   import ebs_pkg::*;
#(
   parameter int N_AREA = 8,
   parameter int N_DIR  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [1:0]                 sel,
   input  logic [WAIT_W*N_AREA-1:0]   wdata,
   output area_cfg_t [N_AREA-1:0]     cfg_o,
   output logic [N_DIR-1:0]           dir_o
);
   for (genvar i = 0; i < N_AREA; i++) begin : g_area
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_o[i].narrow <= 1'b0;
            cfg_o[i].slow   <= 1'b1;
            cfg_o[i].waits  <= '1;
         end else if (we) begin
            case (sel)
               2'd0:    cfg_o[i].narrow <= wdata[i];
               2'd1:    cfg_o[i].slow   <= wdata[i];
               2'd2:    cfg_o[i].waits  <= wdata[WAIT_W*i +: WAIT_W];
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_o <= '0;
      else if (we && sel == 2'd3) dir_o <= wdata[N_DIR-1:0];
   end

   // R9
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == 2'd3) |=> (dir_o == $past(wdata[N_DIR-1:0])));
endmodule

// File: rtl/ebs_cs_drv.sv
module ebs_cs_drv #(
   parameter int N_AREA = 8,
   parameter int N_DIR  = 3,
   localparam int AREA_W = $clog2(N_AREA)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [AREA_W-1:0] area,
   input  logic [N_DIR-1:0]  dir,
   output logic [N_AREA-1:0] cs_n,
   output logic [N_AREA-1:0] cs_oe
);
   for (genvar i = 0; i < N_AREA; i++) begin : g_pin
      assign cs_n[i] = !(active && area == AREA_W'(i));
      if (i >= 1 && i <= N_DIR) begin : g_dir
         assign cs_oe[i] = dir[i-1];
      end else begin : g_fixed
         assign cs_oe[i] = 1'b1;
      end
   end

   // R1
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
   import ebs_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int AREA_W = 3,
   localparam int MAX_LEN = 3 + (2**WAIT_W - 1),
   localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [AREA_W-1:0] area,
   input  logic              is_word,
   input  logic              is_write,
   input  area_cfg_t         cfg,
   output logic              active,
   output logic              done,
   output logic              busy,
   output logic [AREA_W-1:0] area_o,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_we
);
   seq_st_e     st_q;
   logic [LEN_W-1:0] len_q, cnt_q;
   logic        split_q, part_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         len_q    <= '0;
         cnt_q    <= '0;
         split_q  <= 1'b0;
         part_q   <= 1'b0;
         area_o   <= '0;
         bus_addr <= '0;
         bus_we   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               st_q    <= ST_ACC;
               area_o  <= area;
               len_q   <= cfg.slow ? LEN_W'(3) + LEN_W'(cfg.waits) : LEN_W'(2);
               cnt_q   <= LEN_W'(1);
               split_q <= is_word && cfg.narrow;
               part_q  <= 1'b0;
               bus_we  <= is_write;
               bus_addr <= (is_word && cfg.narrow) ? {addr[ADDR_W-1:1], 1'b0} : addr;
            end
            ST_ACC: begin
               if (cnt_q == len_q) begin
                  if (split_q && !part_q) begin
                     part_q      <= 1'b1;
                     cnt_q       <= LEN_W'(1);
                     bus_addr[0] <= 1'b1;
                  end else begin
                     st_q <= ST_FIN;
                  end
               end else begin
                  cnt_q <= cnt_q + LEN_W'(1);
               end
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign active = (st_q == ST_ACC);
   assign done   = (st_q == ST_FIN);
   assign busy   = (st_q != ST_IDLE);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy && !done);
   // R8
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(!busy));
   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> ($stable(len_q) && $stable(area_o)));
   // R5
   split_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(part_q) |-> (split_q && bus_addr[0]));
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
   import ebs_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int N_AREA = 8,
   parameter int N_DIR  = 3,
   localparam int AREA_W = $clog2(N_AREA),
   localparam int CFG_W  = WAIT_W * N_AREA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_word,
   output logic              busy,
   output logic              done,
   output logic [N_AREA-1:0] cs_n,
   output logic [N_AREA-1:0] cs_oe,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_we
);
   if (N_AREA < N_DIR + 1 || (N_AREA & (N_AREA - 1)) != 0) begin : g_bad_area
      $error("N_AREA must be a power of two above N_DIR");
   end
   if (ADDR_W <= AREA_W) begin : g_bad_addr
      $error("ADDR_W too small for the area count");
   end

   area_cfg_t [N_AREA-1:0] cfg_all;
   logic [N_DIR-1:0]       dir;
   logic [AREA_W-1:0]      req_area, cur_area;
   logic                   active;

   assign req_area = req_addr[ADDR_W-1 -: AREA_W];

   ebs_cfg_regs #(.N_AREA(N_AREA), .N_DIR(N_DIR)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .wdata(cfg_wdata), .cfg_o(cfg_all), .dir_o(dir)
   );

   ebs_seq #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(req_valid), .addr(req_addr),
      .area(req_area), .is_word(req_word), .is_write(req_write),
      .cfg(cfg_all[req_area]), .active(active), .done(done), .busy(busy),
      .area_o(cur_area), .bus_addr(bus_addr), .bus_we(bus_we)
   );

   ebs_cs_drv #(.N_AREA(N_AREA), .N_DIR(N_DIR)) u_cs (
      .clk(clk), .rst_n(rst_n), .active(active), .area(cur_area),
      .dir(dir), .cs_n(cs_n), .cs_oe(cs_oe)
   );

   // R7
   idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n == '1));
endmodule

// File: tb/ext_bus_seq_tb.sv
module ext_bus_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [15:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [23:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic        busy, done, bus_we;
   logic [7:0]  cs_n, cs_oe;
   logic [23:0] bus_addr;

   int n_run = 0;
   int n_fail = 0;

   bit       m_width [8];
   bit       m_ast   [8];
   bit [1:0] m_wait  [8];
   bit [2:0] m_dir;

   always #2 clk = ~clk;

   ext_bus_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_word(req_word), .busy(busy), .done(done),
      .cs_n(cs_n), .cs_oe(cs_oe), .bus_addr(bus_addr), .bus_we(bus_we)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_len(input int a);
      return m_ast[a] ? 3 + int'(m_wait[a]) : 2;
   endfunction

   function automatic logic [7:0] exp_oe();
      return {4'hF, m_dir, 1'b1};
   endfunction

   task automatic model_write(input logic [1:0] s, input logic [15:0] d);
      for (int i = 0; i < 8; i++) begin
         case (s)
            2'd0: m_width[i] = d[i];
            2'd1: m_ast[i]   = d[i];
            2'd2: m_wait[i]  = d[2*i +: 2];
            default: ;
         endcase
      end
      if (s == 2'd3) m_dir = d[2:0];
   endtask

   // R11: configuration write encodings
   task automatic cfg_write(input logic [1:0] s, input logic [15:0] d);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model_write(s, d);
   endtask

   task automatic run_acc(input logic [23:0] a, input bit word, input bit wr,
                          input bit mid, input bit stray, input string len_tag);
      int area, n, total;
      bit split, cs_ok;
      logic [23:0] a0, a1;
      logic [1:0]  mid_sel;
      logic [15:0] mid_dat;
      area  = int'(a[23:21]);
      n     = exp_len(area);
      split = word && m_width[area];
      total = split ? 2 * n : n;
      a0    = split ? {a[23:1], 1'b0} : a;
      a1    = {a[23:1], 1'b1};
      mid_sel = 2'd2; mid_dat = '0;
      cs_ok = 1'b1;
      req_valid = 1'b1; req_addr = a; req_word = word; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      for (int s = 0; s <= total + 1; s++) begin
         if (s == 0) begin
            check(cs_n == ~(8'd1 << area), "R1", cs_n, ~(8'd1 << area));
            check(bus_addr == a0, split ? "R5" : "R6", bus_addr, a0);
            check(busy && bus_we == wr, "R7", {busy, bus_we}, {1'b1, wr});
            if (mid) begin
               // R10: shorten the running area's setting mid-access
               mid_sel = $urandom_range(1) ? 2'd1 : 2'd2;
               mid_dat = 16'h0000;
               cfg_we = 1'b1; cfg_sel = mid_sel; cfg_wdata = mid_dat;
            end
            if (stray) begin
               req_valid = 1'b1;
               req_addr  = {3'(area + 1), a[20:0]};
            end
         end
         if (s == 1) cfg_we = 1'b0;
         if (split && s == n)
            check(bus_addr == a1, "R5", bus_addr, a1);
         if (s < total && cs_n != ~(8'd1 << area)) cs_ok = 1'b0;
         if (s == total) begin
            check(cs_ok && cs_n == 8'hFF, len_tag, total, total);
            check(done == 1'b1, "R7", done, 1);
         end
         if (s == total + 1) begin
            req_valid = 1'b0;
            check(!busy && !done && cs_n == 8'hFF, "R8", {busy, done, cs_n}, 10'h0FF);
         end
         if (s <= total) @(negedge clk);
      end
      if (mid) model_write(mid_sel, mid_dat);
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < 8; i++) begin
         m_width[i] = 1'b0; m_ast[i] = 1'b1; m_wait[i] = 2'd3;
      end
      m_dir = 3'b000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 / R9 reset state
      check(cs_n == 8'hFF && !busy && !done, "R2", {busy, done, cs_n}, 10'h0FF);
      check(cs_oe == 8'hF1, "R9", cs_oe, 8'hF1);
      run_acc(24'h000100, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
      // R3: 2-state ignores the wait field
      cfg_write(2'd1, 16'hFFFB);
      run_acc(24'h400010, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
      // R4: each wait count
      for (int w = 0; w < 4; w++) begin
         cfg_write(2'd2, {8{w[1:0]}});
         run_acc(24'hC00020, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      end
      // R5: word to 8-bit area, R6 byte to 8-bit area
      cfg_write(2'd0, 16'h0020);
      cfg_write(2'd2, 16'h0400);
      run_acc(24'hA00033, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
      run_acc(24'hA00033, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
      cfg_write(2'd1, 16'h0000);
      run_acc(24'hA00044, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
      cfg_write(2'd1, 16'hFFFF);
      // R9 direction bits
      cfg_write(2'd3, 16'h0005);
      check(cs_oe == exp_oe(), "R9", cs_oe, exp_oe());
      // R10 mid-access write, then next access uses it
      cfg_write(2'd2, 16'hFFFF);
      run_acc(24'h200000, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
      run_acc(24'h200000, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
      // R7 requests during an access are ignored
      run_acc(24'hE00008, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
      // random mix
      for (int k = 0; k < 80; k++) begin
         if ($urandom_range(3) == 0) begin
            logic [1:0] s;
            s = 2'($urandom_range(3));
            cfg_write(s, 16'($urandom));
            if (s == 2'd3) check(cs_oe == exp_oe(), "R9", cs_oe, exp_oe());
         end
         run_acc(24'($urandom), 1'($urandom_range(1)), 1'($urandom_range(1)),
                 ($urandom_range(7) == 0), ($urandom_range(7) == 0), "R4");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule